// File: doc/BRIEF.md
# SDRAM Byte-Lane Mask Datapath

This block sits between a memory controller and a 72-bit SDRAM data bus. It applies a per-byte mask to each transfer. For writes, the mask takes effect at once. For reads, it takes effect after a fixed two-cycle delay. The bus is split into nine 8-bit lanes. Mask bit `i` governs bus bits `[8*i+7 : 8*i]`.

Each cycle the controller presents a command strobe, a direction bit, write data, and a nine-bit mask.

- **Writes:** the block turns the mask into byte write enables for a simple array model. It also passes the write data through unchanged.
- **Reads:** the block delays the inverted mask through a two-stage register per lane. That delayed value decides which lanes drive the array's read data and which lanes float.

Command and address handling, CAS latency and bus turnaround belong to other blocks.

Top module: `sdram_byte_mask_path`

## Requirements
- R1: While reset is asserted, and for the first two cycles after its release, every lane output enable is 0 and every lane of `dq_o` is 0.
- R2: In a cycle with `cmd_vld_i`=1 and `cmd_wr_i`=1, `byte_we_o[i]` is 1 exactly when `mask_i[i]` is 0, in that same cycle.
- R3: In a cycle that is not a write (`cmd_vld_i`=0, or `cmd_wr_i`=0 for a read), `byte_we_o` is all zeros, whatever the mask.
- R4: `wdata_o` always equals `wdata_i` in the same cycle.
- R5: If a read (`cmd_vld_i`=1, `cmd_wr_i`=0) is sampled with `mask_i[i]`=0, then `dq_oe_o[i]` is 1 in the cycle two clock edges later.
- R6: If a read is sampled with `mask_i[i]`=1, then `dq_oe_o[i]` is 0 in the cycle two clock edges later.
- R7: Reads on consecutive cycles each get their own mask two cycles later, with no mixing between neighbours.
- R8: If the cycle two edges earlier held no read (a write or idle), every `dq_oe_o` bit is 0.
- R9: Each lane of `dq_o` carries the matching lane of `rdata_i` when its `dq_oe_o` bit is 1, and is 0 when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_vld_i | input | 1 | A transfer is present this cycle |
| cmd_wr_i | input | 1 | 1 = write, 0 = read |
| mask_i | input | 9 | Per-lane mask, 1 = suppress the lane |
| wdata_i | input | 72 | Write data from the controller |
| rdata_i | input | 72 | Read data from the array model |
| byte_we_o | output | 9 | Per-byte write enables to the array |
| wdata_o | output | 72 | Write data to the array |
| dq_oe_o | output | 9 | Per-lane bus drive enable |
| dq_o | output | 72 | Lane-gated read data |

## Verification
The bench concentrates on the edges between the two latencies:

- **Read followed directly by writes.** The enables from the read must appear during the write cycles, while the write enables follow the write mask in the same cycle. A design that shared one delay for both directions would drive the wrong lanes or write masked bytes.
- **Alternating complementary masks on back-to-back reads.** A pipeline that was one stage short or long, or that merged neighbouring masks, shows up as inverted lanes.
- **The two cycles after reset.** A pipeline not cleared by reset would drive the bus before any read had been issued.

// File: rtl/sdram_mask_pkg.sv
package sdram_mask_pkg;
  parameter int unsigned LANES  = 9;
  parameter int unsigned LANE_W = 8;
  // read-side mask delay is fixed by the bus protocol
  localparam int unsigned RD_LAT = 2;

  typedef enum logic {
    CMD_RD = 1'b0,
    CMD_WR = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/dqm_wr_gate.sv
module dqm_wr_gate #(
  parameter int unsigned LANES  = 9,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic             wr_vld_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [LANES-1:0] byte_we_o,
  output logic [BUS_W-1:0] wdata_o
);
  // zero-latency: mask qualifies the data on the same edge
  for (genvar g = 0; g < LANES; g++) begin : g_we
    assign byte_we_o[g] = wr_vld_i & ~mask_i[g];
  end
  assign wdata_o = wdata_i;
endmodule

// File: rtl/dqm_rd_pipe.sv
module dqm_rd_pipe
  import sdram_mask_pkg::*;
#(
  parameter int unsigned LANES = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_vld_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] lane_en_o
);
  logic [LANES-1:0] stage_q [RD_LAT];

  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= rd_vld_i ? ~mask_i : '0;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign lane_en_o = stage_q[RD_LAT-1];

  // cycles since reset, saturating; used only to gate history checks
  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
  end

  p_rd_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd2 && $past(rd_vld_i, 2)) |-> lane_en_o == ~$past(mask_i, 2));
  p_rd_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd2 && !$past(rd_vld_i, 2)) |-> lane_en_o == '0);
  p_rd_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q != 2'd2) |-> lane_en_o == '0);
endmodule

// File: rtl/dqm_lane_drive.sv
module dqm_lane_drive #(
  parameter int unsigned LANES  = 9,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [BUS_W-1:0] rdata_i,
  output logic [LANES-1:0] dq_oe_o,
  output logic [BUS_W-1:0] dq_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_oe_o[g] = lane_en_i[g];
    assign dq_o[g*LANE_W +: LANE_W] =
      lane_en_i[g] ? rdata_i[g*LANE_W +: LANE_W] : '0;

    p_float_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dq_oe_o[g] |-> dq_o[g*LANE_W +: LANE_W] == '0);
    p_drive_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dq_oe_o[g] |-> dq_o[g*LANE_W +: LANE_W] == rdata_i[g*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/sdram_byte_mask_path.sv
module sdram_byte_mask_path
  import sdram_mask_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  parameter int unsigned L_WIDTH = LANE_W,
  localparam int unsigned BUS_W  = N_LANES * L_WIDTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_vld_i,
  input  logic               cmd_wr_i,
  input  logic [N_LANES-1:0] mask_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [BUS_W-1:0]   rdata_i,
  output logic [N_LANES-1:0] byte_we_o,
  output logic [BUS_W-1:0]   wdata_o,
  output logic [N_LANES-1:0] dq_oe_o,
  output logic [BUS_W-1:0]   dq_o
);
  cmd_kind_e        kind;
  logic             wr_vld, rd_vld;
  logic [N_LANES-1:0] lane_en;

  assign kind   = cmd_kind_e'(cmd_wr_i);
  assign wr_vld = cmd_vld_i && (kind == CMD_WR);
  assign rd_vld = cmd_vld_i && (kind == CMD_RD);

  dqm_wr_gate #(.LANES(N_LANES), .LANE_W(L_WIDTH)) u_wr_gate (
    .wr_vld_i (wr_vld),
    .mask_i   (mask_i),
    .wdata_i  (wdata_i),
    .byte_we_o(byte_we_o),
    .wdata_o  (wdata_o)
  );

  dqm_rd_pipe #(.LANES(N_LANES)) u_rd_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_vld_i (rd_vld),
    .mask_i   (mask_i),
    .lane_en_o(lane_en)
  );

  dqm_lane_drive #(.LANES(N_LANES), .LANE_W(L_WIDTH)) u_drive (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_en_i(lane_en),
    .rdata_i  (rdata_i),
    .dq_oe_o  (dq_oe_o),
    .dq_o     (dq_o)
  );

  p_we_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld_i && cmd_wr_i) |-> byte_we_o == ~mask_i);
  p_we_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_vld_i && cmd_wr_i) |-> byte_we_o == '0);
  p_wdata_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_o == wdata_i);
endmodule

// File: tb/sim_sdram_byte_mask_path.sv
module sim_sdram_byte_mask_path;
  localparam int NL = 9;
  localparam int LW = 8;
  localparam int BW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_vld_i = 1'b0, cmd_wr_i = 1'b0;
  logic [NL-1:0] mask_i = '0;
  logic [BW-1:0] wdata_i = '0, rdata_i = '0;
  logic [NL-1:0] byte_we_o, dq_oe_o;
  logic [BW-1:0] wdata_o, dq_o;

  int checks = 0;
  int failures = 0;
  logic [NL-1:0] oe_q[$];

  always #4 clk = ~clk;

  sdram_byte_mask_path u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld_i), .cmd_wr_i(cmd_wr_i),
    .mask_i(mask_i), .wdata_i(wdata_i), .rdata_i(rdata_i),
    .byte_we_o(byte_we_o), .wdata_o(wdata_o), .dq_oe_o(dq_oe_o), .dq_o(dq_o)
  );

  function automatic logic [BW-1:0] rnd_bus();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[BW-1:0];
  endfunction

  function automatic logic [BW-1:0] gate(logic [NL-1:0] en, logic [BW-1:0] d);
    logic [BW-1:0] r;
    for (int i = 0; i < NL; i++) r[i*LW +: LW] = en[i] ? d[i*LW +: LW] : 8'h00;
    return r;
  endfunction

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational and pipelined outputs
  task automatic step(input logic vld, input logic wr, input logic [NL-1:0] m, input string tag);
    logic [NL-1:0] exp_oe;
    logic [NL-1:0] exp_we;
    @(negedge clk);
    cmd_vld_i = vld; cmd_wr_i = wr; mask_i = m;
    wdata_i = rnd_bus(); rdata_i = rnd_bus();
    #1;
    exp_oe = oe_q.pop_front();
    oe_q.push_back((vld && !wr) ? ~m : '0);
    exp_we = (vld && wr) ? ~m : '0;
    check((vld && wr) ? {"R2 ", tag} : {"R3 ", tag}, BW'(byte_we_o), BW'(exp_we));
    check({"R4 ", tag}, wdata_o, wdata_i);
    check({"R5 R6 R8 ", tag}, BW'(dq_oe_o), BW'(exp_oe));
    check({"R9 ", tag}, dq_o, gate(exp_oe, rdata_i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rdata_i = {BW{1'b1}};
    cmd_vld_i = 1'b1; cmd_wr_i = 1'b0; mask_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset oe", BW'(dq_oe_o), '0);
    check("R1 reset dq", dq_o, '0);
    cmd_vld_i = 1'b0;
    rst_ni = 1'b1;
    oe_q.push_back('0);
    oe_q.push_back('0);

    // R1: first two cycles after release float
    step(1'b0, 1'b0, '0, "R1 post-reset");
    step(1'b0, 1'b0, '0, "R1 post-reset");
    // R2: write mask patterns
    step(1'b1, 1'b1, 9'h000, "wr none");
    step(1'b1, 1'b1, 9'h1FF, "wr all");
    step(1'b1, 1'b1, 9'h155, "wr alt");
    step(1'b1, 1'b1, 9'h0AA, "wr alt");
    // R7: back-to-back reads with alternating masks
    step(1'b1, 1'b0, 9'h155, "R7 b2b");
    step(1'b1, 1'b0, 9'h0AA, "R7 b2b");
    step(1'b1, 1'b0, 9'h155, "R7 b2b");
    step(1'b1, 1'b0, 9'h0AA, "R7 b2b");
    step(1'b1, 1'b0, 9'h000, "R5 all on");
    step(1'b1, 1'b0, 9'h1FF, "R6 all off");
    // read-to-write transition
    step(1'b1, 1'b1, 9'h0F0, "rd2wr");
    step(1'b1, 1'b1, 9'h10F, "rd2wr");
    step(1'b0, 1'b0, 9'h1FF, "R8 idle");
    step(1'b1, 1'b0, 9'h033, "rd");
    step(1'b1, 1'b1, 9'h1CC, "rd2wr");
    step(1'b0, 1'b1, 9'h000, "R3 idle wr-bit");
    step(1'b1, 1'b0, 9'h1FE, "rd");
    step(1'b0, 1'b0, 9'h000, "idle");
    step(1'b0, 1'b0, 9'h000, "idle");
    for (int k = 0; k < 60; k++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[0], r[1], r[10:2], "mix");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule